// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. The host hands it one character at a time through a valid/ready handshake. The transmitter turns the character into a start bit, 5 to 9 data bits, an optional parity or address-marker bit and a stop period. The receiver watches the incoming line and rebuilds characters. It delivers each one with its own error flags and holds it until the host acknowledges it with a read strobe.

Bit timing comes from an external divider that pulses `baud_tick` at 8 or 16 times the bit rate. The core counts those ticks to place every edge it sends and every sample it takes. Frame settings are run-time inputs and are expected to stay stable while a character is in flight. The settings cover length, parity, stop length, bit order, oversampling, guard time, idle time-out and test path.

Three test paths reroute the pins. Local loopback sends the transmitter into the receiver and keeps the pin quiet. Remote loopback copies the input pin to the output pin with the receiver idle. Echo copies the input pin to the output pin while the receiver keeps working.

Top module: `async_serial_core`

## Requirements
- R1: After reset `txd` is high, `tx_ready` is high, and `rx_valid`, `rx_par_err`, `rx_frm_err`, `rx_overrun`, `rx_break`, `rx_mark` and `rx_timeout` are all low.
- R2: `cfg_len` (5 to 9) sets the number of data bits. A received character carries exactly that many bits in `rx_data`, and all higher bits of `rx_data` are zero.
- R3: With `cfg_msb_first` = 0 the data bits go out least significant first. With 1 they go out most significant first. The receiver undoes the same order.
- R4: `cfg_par` encodes 0 = no parity, 1 = even, 2 = odd, 3 = address marker. The parity bit follows the last data bit on the line. The receiver raises `rx_par_err` when an even or odd parity bit disagrees with the data.
- R5: `cfg_stop` encodes 0 = 1, 1 = 1.5 and 2 = 2 stop bit periods. `tx_ready` returns exactly (1 + data bits + parity bits) x N + stop ticks + guard x N ticks after the accepting edge, where N is the tick count per bit.
- R6: `cfg_os8` = 1 gives N = 8 ticks per bit and 0 gives N = 16, for both directions.
- R7: A stop bit sampled low raises `rx_frm_err` for that character.
- R8: If a character completes while the previous one is still unread, `rx_overrun` is set and `rx_data` takes the newer character. A read clears both `rx_valid` and `rx_overrun`.
- R9: While `tx_break` is high and the transmitter is idle, `txd` is low and `tx_ready` is low. A received frame whose data, parity and stop bits are all low is reported with `rx_break` = 1, `rx_frm_err` = 1 and `rx_data` = 0. No further character starts until the line has gone high again.
- R10: When `cfg_timeout` is nonzero, `rx_timeout` rises after that many idle bit periods following a received character. It clears at the next start bit.
- R11: `cfg_guard` idle bit periods are held high after each stop period before `tx_ready` returns.
- R12: In marker mode the parity slot carries `tx_mark`. The receiver reports that bit on `rx_mark`, and `rx_mark` is 0 in the other parity modes.
- R13: `cfg_test` encodes 0 = normal, 1 = local loopback (`txd` held high, receiver fed by the transmitter), 2 = remote loopback (`txd` = `rxd`, receiver idle) and 3 = echo (`txd` = `rxd`, receiver fed by `rxd`).
- R14: The receiver re-checks the line N/2 ticks after a falling edge. A line that is high again at that point is treated as noise, and no character results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick from external divider |
| cfg_len | input | 4 | Data bits per character, 5 to 9 |
| cfg_par | input | 2 | Parity mode (0 none, 1 even, 2 odd, 3 marker) |
| cfg_stop | input | 2 | Stop length (0 one, 1 one and a half, 2 two) |
| cfg_msb_first | input | 1 | Most significant data bit first |
| cfg_os8 | input | 1 | 8 ticks per bit when high, 16 when low |
| cfg_guard | input | GW | Idle bit periods between transmitted characters |
| cfg_timeout | input | GW | Idle bit periods before receive time-out, 0 disables |
| cfg_test | input | 2 | Test path (0 normal, 1 local, 2 remote, 3 echo) |
| tx_data | input | 9 | Character to send |
| tx_mark | input | 1 | Marker bit value in marker mode |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter accepts a character |
| tx_break | input | 1 | Hold the line low while idle |
| rx_data | output | 9 | Last received character |
| rx_valid | output | 1 | Unread character present |
| rx_read | input | 1 | Consume the held character |
| rx_par_err | output | 1 | Parity mismatch on held character |
| rx_frm_err | output | 1 | Stop bit low on held character |
| rx_overrun | output | 1 | Held character replaced before it was read |
| rx_break | output | 1 | Held character is a break |
| rx_mark | output | 1 | Marker bit of held character |
| rx_timeout | output | 1 | Line idle past the time-out |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |

## Verification
The assertions watch relations that must hold on every cycle. An overrun can only rise while a character is held. A completed character never carries bits above the programmed length. A break always lands as zero data with a framing error. A rejected start always returns the receiver to idle. The time-out only rises out of the idle state. The transmitter is never ready on the cycle after it accepts. Bit order, parity values, stop and guard durations, the routing of each test path and the end-to-end agreement between transmitter and receiver over many frame formats depend on whole frames. Only the bench scenarios can show these, by timing the handshake and sampling `txd` at mid-bit.

// File: rtl/async_serial_pkg.sv
package async_serial_pkg;
  localparam int unsigned DMAX = 9;

  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_MARK = 2'd3} par_mode_e;
  typedef enum logic [1:0] {TM_NORMAL = 2'd0, TM_LOCAL = 2'd1, TM_REMOTE = 2'd2, TM_ECHO = 2'd3} test_mode_e;

  function automatic logic [4:0] bit_ticks(input logic os8);
    return os8 ? 5'd8 : 5'd16;
  endfunction

  function automatic logic [5:0] stop_ticks(input logic [1:0] stop, input logic os8);
    logic [5:0] n;
    n = {1'b0, bit_ticks(os8)};
    case (stop)
      2'd1:    return n + (n >> 1);
      2'd2:    return n << 1;
      default: return n;
    endcase
  endfunction

  function automatic logic [DMAX-1:0] len_mask(input logic [3:0] len);
    logic [DMAX:0] t;
    t = ((DMAX+1)'(1) << len) - (DMAX+1)'(1);
    return t[DMAX-1:0];
  endfunction

  // Reverse the low len bits when msb is set; identity otherwise.
  function automatic logic [DMAX-1:0] reorder(input logic [DMAX-1:0] v, input logic [3:0] len,
                                              input logic msb);
    logic [DMAX-1:0] r;
    r = '0;
    for (int i = 0; i < DMAX; i++)
      if (i < int'(len)) r[i] = msb ? v[int'(len)-1-i] : v[i];
    return r;
  endfunction

  function automatic logic par_value(input logic [DMAX-1:0] d, input logic [1:0] mode, input logic mark);
    case (mode)
      PAR_EVEN: return ^d;
      PAR_ODD:  return ~^d;
      PAR_MARK: return mark;
      default:  return 1'b0;
    endcase
  endfunction

  // Data plus parity slot count.
  function automatic logic [3:0] slot_bits(input logic [3:0] len, input logic [1:0] mode);
    return len + ((mode != PAR_NONE) ? 4'd1 : 4'd0);
  endfunction
endpackage

// File: rtl/async_serial_tx.sv
module async_serial_tx import async_serial_pkg::*; #(
  parameter int unsigned GW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [3:0]      cfg_len,
  input  logic [1:0]      cfg_par,
  input  logic [1:0]      cfg_stop,
  input  logic            cfg_msb_first,
  input  logic            cfg_os8,
  input  logic [GW-1:0]   cfg_guard,
  input  logic [DMAX-1:0] tx_data,
  input  logic            tx_mark,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic            tx_break,
  output logic            line
);
  localparam int unsigned CW = GW + 5;
  localparam int unsigned FW = DMAX + 2;

  typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_STOP, T_GUARD} tx_st_e;
  tx_st_e st;
  logic [FW-1:0] sh, frame;
  logic [3:0] bit_idx;
  logic [CW-1:0] cnt, bit_end, stop_end, guard_end;
  logic [DMAX-1:0] body, dmask;
  logic pbit, tx_accept;

  assign dmask     = tx_data & len_mask(cfg_len);
  assign body      = reorder(dmask, cfg_len, cfg_msb_first);
  assign pbit      = par_value(dmask, cfg_par, tx_mark);
  assign bit_end   = CW'(bit_ticks(cfg_os8)) - CW'(1);
  assign stop_end  = CW'(stop_ticks(cfg_stop, cfg_os8)) - CW'(1);
  assign guard_end = CW'(cfg_guard) * CW'(bit_ticks(cfg_os8)) - CW'(1);
  assign tx_ready  = (st == T_IDLE) && !tx_break;
  assign tx_accept = tx_valid && tx_ready;
  assign line      = (st == T_SHIFT) ? sh[0] : !((st == T_IDLE) && tx_break);

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DMAX; i++)
      if (i < int'(cfg_len)) frame[i+1] = body[i];
    if (cfg_par != PAR_NONE) frame[int'(cfg_len)+1] = pbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; sh <= '1; cnt <= '0; bit_idx <= '0;
    end else begin
      case (st)
        T_IDLE: if (tx_accept) begin
          sh <= frame; cnt <= '0; bit_idx <= '0; st <= T_SHIFT;
        end
        T_SHIFT: if (tick) begin
          if (cnt == bit_end) begin
            cnt <= '0;
            sh  <= {1'b1, sh[FW-1:1]};
            if (bit_idx == slot_bits(cfg_len, cfg_par)) st <= T_STOP;
            else bit_idx <= bit_idx + 4'd1;
          end else cnt <= cnt + CW'(1);
        end
        T_STOP: if (tick) begin
          if (cnt == stop_end) begin
            cnt <= '0;
            st  <= (cfg_guard == '0) ? T_IDLE : T_GUARD;
          end else cnt <= cnt + CW'(1);
        end
        default: if (tick) begin
          if (cnt == guard_end) begin cnt <= '0; st <= T_IDLE; end
          else cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  // R5: a character in flight keeps the handshake closed
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !tx_ready);
endmodule

// File: rtl/async_serial_rx.sv
module async_serial_rx import async_serial_pkg::*; #(
  parameter int unsigned GW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line,
  input  logic [3:0]      cfg_len,
  input  logic [1:0]      cfg_par,
  input  logic            cfg_msb_first,
  input  logic            cfg_os8,
  input  logic [GW-1:0]   cfg_timeout,
  input  logic            rd,
  output logic [DMAX-1:0] rx_data,
  output logic            rx_valid,
  output logic            rx_par_err,
  output logic            rx_frm_err,
  output logic            rx_ovr,
  output logic            rx_brk,
  output logic            rx_mark,
  output logic            rx_timeout
);
  localparam int unsigned CW = GW + 5;

  typedef enum logic [2:0] {R_IDLE, R_START, R_BITS, R_STOP, R_HOLD} rx_st_e;
  rx_st_e st;
  logic [1:0] sync;
  logic line_s, armed, rx_done, mid_false, brk_ev, perr;
  logic [3:0] idx, nb;
  logic [CW-1:0] cnt, to_cnt, bit_end, half_end, to_end;
  logic [DMAX:0] rsh, raw;
  logic [DMAX-1:0] data_rx, dmask;

  assign line_s    = sync[1];
  assign nb        = slot_bits(cfg_len, cfg_par);
  assign bit_end   = CW'(bit_ticks(cfg_os8)) - CW'(1);
  assign half_end  = CW'(bit_ticks(cfg_os8) >> 1) - CW'(1);
  assign to_end    = CW'(cfg_timeout) * CW'(bit_ticks(cfg_os8)) - CW'(1);
  assign raw       = rsh >> (4'(DMAX + 1) - nb);
  assign dmask     = raw[DMAX-1:0] & len_mask(cfg_len);
  assign data_rx   = reorder(dmask, cfg_len, cfg_msb_first);
  assign perr      = ((cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD)) &&
                     (raw[cfg_len] != par_value(dmask, cfg_par, 1'b0));
  assign rx_done   = (st == R_STOP) && tick && (cnt == bit_end);
  assign brk_ev    = !line_s && (raw == '0);
  assign mid_false = (st == R_START) && tick && (cnt == half_end) && line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; st <= R_IDLE; cnt <= '0; idx <= '0; rsh <= '0;
      rx_data <= '0; rx_valid <= 1'b0; rx_par_err <= 1'b0; rx_frm_err <= 1'b0;
      rx_ovr <= 1'b0; rx_brk <= 1'b0; rx_mark <= 1'b0;
      armed <= 1'b0; to_cnt <= '0; rx_timeout <= 1'b0;
    end else begin
      sync <= {sync[0], line};
      if (rd && rx_valid) begin rx_valid <= 1'b0; rx_ovr <= 1'b0; end
      case (st)
        R_IDLE: if (tick) begin
          if (!line_s) begin
            st <= R_START; cnt <= '0; rsh <= '0; rx_timeout <= 1'b0; armed <= 1'b0;
          end else if (armed) begin
            if (to_cnt == to_end) begin rx_timeout <= 1'b1; armed <= 1'b0; end
            else to_cnt <= to_cnt + CW'(1);
          end
        end
        R_START: if (tick) begin
          if (cnt == half_end) begin
            cnt <= '0; idx <= '0;
            st  <= line_s ? R_IDLE : R_BITS;
          end else cnt <= cnt + CW'(1);
        end
        R_BITS: if (tick) begin
          if (cnt == bit_end) begin
            cnt <= '0;
            rsh <= {line_s, rsh[DMAX:1]};
            if (idx == nb - 4'd1) st <= R_STOP;
            else idx <= idx + 4'd1;
          end else cnt <= cnt + CW'(1);
        end
        R_STOP: if (tick) begin
          if (rx_done) begin
            cnt        <= '0;
            rx_valid   <= 1'b1;
            rx_data    <= data_rx;
            rx_par_err <= perr;
            rx_frm_err <= !line_s;
            rx_brk     <= brk_ev;
            rx_mark    <= (cfg_par == PAR_MARK) && raw[cfg_len];
            rx_ovr     <= rx_valid && !rd;
            armed      <= (cfg_timeout != '0);
            to_cnt     <= '0;
            st         <= line_s ? R_IDLE : R_HOLD;
          end else cnt <= cnt + CW'(1);
        end
        default: if (line_s) st <= R_IDLE;
      endcase
    end
  end

  // R8: overrun only rises over a held character
  a_r8_overrun_needs_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid));
  // R2: no bit beyond the programmed length survives
  a_r2_upper_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> ((rx_data & ~len_mask($past(cfg_len))) == '0));
  // R9: an all-low frame is reported as a break with zero data
  a_r9_break_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && brk_ev) |=> (rx_brk && rx_frm_err && rx_data == '0));
  // R14: a start that vanished at mid-bit goes back to idle
  a_r14_false_start_drop: assert property (@(posedge clk) disable iff (!rst_n)
    mid_false |=> (st == R_IDLE));
  // R10: time-out only rises while idle
  a_r10_timeout_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_timeout) |-> $past(st == R_IDLE));
endmodule

// File: rtl/async_serial_core.sv
module async_serial_core import async_serial_pkg::*; #(
  parameter int unsigned GW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            baud_tick,
  input  logic [3:0]      cfg_len,
  input  logic [1:0]      cfg_par,
  input  logic [1:0]      cfg_stop,
  input  logic            cfg_msb_first,
  input  logic            cfg_os8,
  input  logic [GW-1:0]   cfg_guard,
  input  logic [GW-1:0]   cfg_timeout,
  input  logic [1:0]      cfg_test,
  input  logic [DMAX-1:0] tx_data,
  input  logic            tx_mark,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic            tx_break,
  output logic [DMAX-1:0] rx_data,
  output logic            rx_valid,
  input  logic            rx_read,
  output logic            rx_par_err,
  output logic            rx_frm_err,
  output logic            rx_overrun,
  output logic            rx_break,
  output logic            rx_mark,
  output logic            rx_timeout,
  input  logic            rxd,
  output logic            txd
);
  logic tx_line, rx_in;

  always_comb begin
    case (cfg_test)
      TM_LOCAL:  begin rx_in = tx_line; txd = 1'b1;    end
      TM_REMOTE: begin rx_in = 1'b1;    txd = rxd;     end
      TM_ECHO:   begin rx_in = rxd;     txd = rxd;     end
      default:   begin rx_in = rxd;     txd = tx_line; end
    endcase
  end

  async_serial_tx #(.GW(GW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .cfg_msb_first(cfg_msb_first), .cfg_os8(cfg_os8), .cfg_guard(cfg_guard),
    .tx_data(tx_data), .tx_mark(tx_mark), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_break(tx_break), .line(tx_line)
  );

  async_serial_rx #(.GW(GW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(rx_in),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_msb_first(cfg_msb_first),
    .cfg_os8(cfg_os8), .cfg_timeout(cfg_timeout), .rd(rx_read),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_ovr(rx_overrun), .rx_brk(rx_break),
    .rx_mark(rx_mark), .rx_timeout(rx_timeout)
  );
endmodule

// File: tb/async_serial_core_bench.sv
module async_serial_core_bench;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic [1:0] cfg_par = 2'd0, cfg_stop = 2'd0, cfg_test = 2'd0;
  logic cfg_msb_first = 1'b0, cfg_os8 = 1'b1;
  logic [7:0] cfg_guard = 8'd0, cfg_timeout = 8'd0;
  logic [8:0] tx_data = '0;
  logic tx_mark = 1'b0, tx_valid = 1'b0, tx_break = 1'b0, rx_read = 1'b0, rxd = 1'b1;
  logic tx_ready, rx_valid, rx_par_err, rx_frm_err, rx_overrun, rx_break, rx_mark, rx_timeout, txd;
  logic [8:0] rx_data;

  int n_chk = 0, n_fail = 0, cur_n = 8, cyc = 0;
  logic samp [32];
  logic saw_low;

  always #2 clk = ~clk;

  async_serial_core u_async_serial_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first), .cfg_os8(cfg_os8),
    .cfg_guard(cfg_guard), .cfg_timeout(cfg_timeout), .cfg_test(cfg_test),
    .tx_data(tx_data), .tx_mark(tx_mark), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_break(tx_break), .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_overrun(rx_overrun),
    .rx_break(rx_break), .rx_mark(rx_mark), .rx_timeout(rx_timeout), .rxd(rxd), .txd(txd)
  );

  typedef struct packed {
    logic [3:0] len; logic [1:0] par; logic [1:0] stop; logic msb; logic os8;
    logic [3:0] guard; logic [8:0] data; logic mark;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd8, 2'd0, 2'd0, 1'b0, 1'b1, 4'd0, 9'h0A5, 1'b0},
    '{4'd5, 2'd1, 2'd2, 1'b0, 1'b1, 4'd0, 9'h1F3, 1'b0},
    '{4'd9, 2'd2, 2'd1, 1'b1, 1'b0, 4'd0, 9'h1C3, 1'b0},
    '{4'd7, 2'd1, 2'd1, 1'b1, 1'b1, 4'd2, 9'h055, 1'b0},
    '{4'd6, 2'd2, 2'd2, 1'b0, 1'b0, 4'd1, 9'h02D, 1'b0},
    '{4'd8, 2'd3, 2'd0, 1'b0, 1'b1, 4'd0, 9'h0F0, 1'b1},
    '{4'd8, 2'd3, 2'd0, 1'b1, 1'b1, 4'd0, 9'h03C, 1'b0},
    '{4'd9, 2'd0, 2'd2, 1'b0, 1'b1, 4'd3, 9'h155, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_time(input int len, input int par, input int stop, input bit os8, input int g);
    int n, st;
    n  = os8 ? 8 : 16;
    st = (stop == 2) ? 2 * n : (stop == 1) ? (3 * n) / 2 : n;
    return (1 + len + ((par != 0) ? 1 : 0)) * n + st + g * n;
  endfunction

  task automatic setup(input int len, input int par, input int stop, input bit msb, input bit os8,
                       input int g, input int tmo, input int tm);
    @(negedge clk);
    cfg_len = 4'(len); cfg_par = 2'(par); cfg_stop = 2'(stop); cfg_msb_first = msb;
    cfg_os8 = os8; cfg_guard = 8'(g); cfg_timeout = 8'(tmo); cfg_test = 2'(tm);
    cur_n = os8 ? 8 : 16;
  endtask

  task automatic send_char(input logic [8:0] d, input logic m);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_mark = m; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0; cyc = 0; saw_low = 1'b0;
    for (int i = 0; i < 32; i++) samp[i] = 1'b1;
    while (!tx_ready && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (!txd) saw_low = 1'b1;
      if ((cyc % cur_n) == cur_n / 2 && cyc / cur_n < 32) samp[cyc / cur_n] = txd;
    end
  endtask

  task automatic drive_bits(input logic [15:0] bits, input int nb);
    for (int i = 0; i < nb; i++) begin
      rxd = bits[i];
      repeat (cur_n) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  // start, data LSB first, optional parity, stop
  function automatic logic [15:0] mk_frame(input logic [8:0] d, input int len, input bit has_p,
                                           input bit p, input bit stopv);
    logic [15:0] f;
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < len; i++) f[i+1] = d[i];
    if (has_p) f[len+1] = p;
    f[len + 1 + (has_p ? 1 : 0)] = stopv;
    return f;
  endfunction

  task automatic wait_rx(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (rx_valid) got = 1'b1; else @(negedge clk);
    end
  endtask

  task automatic do_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit got;
    int lenv;
    logic [8:0] expd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txd && tx_ready, "R1 idle line/ready", int'({txd, tx_ready}), 3);
    check(!rx_valid && !rx_par_err && !rx_frm_err && !rx_overrun && !rx_break && !rx_mark && !rx_timeout,
          "R1 rx flags", int'({rx_valid, rx_par_err, rx_frm_err, rx_overrun, rx_break, rx_mark, rx_timeout}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(txd && tx_ready && !rx_valid, "R1 after release", int'({txd, tx_ready, rx_valid}), 6);

    // Vector walk in local loopback: R2 R3 R4 R5 R6 R11 R12 R13
    foreach (VECS[k]) begin
      setup(VECS[k].len, VECS[k].par, VECS[k].stop, VECS[k].msb, VECS[k].os8, VECS[k].guard, 0, 1);
      send_char(VECS[k].data, VECS[k].mark);
      check(cyc == frame_time(VECS[k].len, VECS[k].par, VECS[k].stop, VECS[k].os8, VECS[k].guard),
            "R5/R6/R11 frame duration", cyc,
            frame_time(VECS[k].len, VECS[k].par, VECS[k].stop, VECS[k].os8, VECS[k].guard));
      check(!saw_low, "R13 local loop keeps txd high", int'(saw_low), 0);
      wait_rx(got);
      lenv = VECS[k].len;
      expd = VECS[k].data & 9'((1 << lenv) - 1);
      check(got && rx_data == expd, "R2/R3 loopback data", int'(rx_data), int'(expd));
      check(!rx_par_err && !rx_frm_err && !rx_break, "R4 clean flags",
            int'({rx_par_err, rx_frm_err, rx_break}), 0);
      check(rx_mark == ((VECS[k].par == 2'd3) && VECS[k].mark), "R12 marker",
            int'(rx_mark), int'((VECS[k].par == 2'd3) && VECS[k].mark));
      do_read();
    end

    // R3 R4: line order and parity value in normal mode
    setup(8, 1, 0, 0, 1, 0, 0, 0);
    send_char(9'h001, 1'b0);
    check(samp[0] == 1'b0, "R3 start bit low", int'(samp[0]), 0);
    check(samp[1] == 1'b1 && samp[8] == 1'b0, "R3 lsb first", int'({samp[1], samp[8]}), 2);
    check(samp[9] == 1'b1 && samp[10] == 1'b1, "R4 even parity + stop", int'({samp[9], samp[10]}), 3);
    setup(8, 2, 0, 1, 1, 0, 0, 0);
    send_char(9'h001, 1'b0);
    check(samp[1] == 1'b0 && samp[8] == 1'b1, "R3 msb first", int'({samp[1], samp[8]}), 1);
    check(samp[9] == 1'b0, "R4 odd parity", int'(samp[9]), 0);
    setup(8, 3, 0, 0, 1, 0, 0, 0);
    send_char(9'h0FF, 1'b1);
    check(samp[9] == 1'b1, "R12 marker on line", int'(samp[9]), 1);

    // R9: transmit break
    setup(8, 0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); tx_break = 1'b1;
    @(negedge clk);
    check(!txd && !tx_ready, "R9 tx break", int'({txd, tx_ready}), 0);
    tx_break = 1'b0;
    @(negedge clk);
    check(txd && tx_ready, "R9 break released", int'({txd, tx_ready}), 3);

    // R4: parity error (even parity of 0x03 is 0, send 1)
    setup(8, 1, 0, 0, 1, 0, 0, 0);
    drive_bits(mk_frame(9'h003, 8, 1, 1'b1, 1'b1), 11);
    wait_rx(got);
    check(got && rx_par_err && rx_data == 9'h003, "R4 parity error", int'({rx_par_err, rx_data}), 515);
    do_read();

    // R7: framing error
    setup(8, 0, 0, 0, 1, 0, 0, 0);
    drive_bits(mk_frame(9'h05A, 8, 0, 1'b0, 1'b0), 10);
    wait_rx(got);
    check(got && rx_frm_err && !rx_break, "R7 framing error", int'({rx_frm_err, rx_break}), 2);
    do_read();

    // R9: receive break, then no extra character after release
    rxd = 1'b0;
    repeat (12 * cur_n) @(negedge clk);
    rxd = 1'b1;
    wait_rx(got);
    check(got && rx_break && rx_frm_err && rx_data == 9'h000, "R9 rx break",
          int'({rx_break, rx_frm_err}), 3);
    do_read();
    repeat (5 * cur_n) @(negedge clk);
    check(!rx_valid, "R9 single break char", int'(rx_valid), 0);

    // R14: short glitch is not a start
    rxd = 1'b0; repeat (2) @(negedge clk); rxd = 1'b1;
    repeat (15 * cur_n) @(negedge clk);
    check(!rx_valid, "R14 glitch rejected", int'(rx_valid), 0);
    drive_bits(mk_frame(9'h0C3, 8, 0, 1'b0, 1'b1), 10);
    wait_rx(got);
    check(got && rx_data == 9'h0C3, "R14 next char intact", int'(rx_data), 195);
    do_read();

    // R8: overrun
    drive_bits(mk_frame(9'h011, 8, 0, 1'b0, 1'b1), 10);
    drive_bits(mk_frame(9'h022, 8, 0, 1'b0, 1'b1), 10);
    repeat (4) @(negedge clk);
    check(rx_overrun && rx_data == 9'h022, "R8 overrun newer kept", int'({rx_overrun, rx_data}), 546);
    do_read();
    check(!rx_valid && !rx_overrun, "R8 read clears", int'({rx_valid, rx_overrun}), 0);

    // R6: 16x oversampling on the receive pin
    setup(7, 0, 0, 0, 0, 0, 0, 0);
    drive_bits(mk_frame(9'h04B, 7, 0, 1'b0, 1'b1), 9);
    wait_rx(got);
    check(got && rx_data == 9'h04B, "R6 16x receive", int'(rx_data), 75);
    do_read();

    // R10: receive time-out after 4 idle bit periods
    setup(8, 0, 0, 0, 1, 0, 4, 0);
    drive_bits(mk_frame(9'h077, 8, 0, 1'b0, 1'b1), 10);
    do_read();
    repeat (16) @(negedge clk);
    check(!rx_timeout, "R10 not yet", int'(rx_timeout), 0);
    repeat (30) @(negedge clk);
    check(rx_timeout, "R10 time-out set", int'(rx_timeout), 1);
    rxd = 1'b0; repeat (3) @(negedge clk);
    check(!rx_timeout, "R10 cleared by start", int'(rx_timeout), 0);
    rxd = 1'b1; repeat (20 * cur_n) @(negedge clk);
    setup(8, 0, 0, 0, 1, 0, 0, 0);

    // R13: remote loopback
    setup(8, 0, 0, 0, 1, 0, 0, 2);
    rxd = 1'b0; @(negedge clk);
    check(!txd, "R13 remote txd follows low", int'(txd), 0);
    rxd = 1'b1; @(negedge clk);
    check(txd, "R13 remote txd follows high", int'(txd), 1);
    drive_bits(mk_frame(9'h081, 8, 0, 1'b0, 1'b1), 10);
    repeat (2 * cur_n) @(negedge clk);
    check(!rx_valid, "R13 remote receiver idle", int'(rx_valid), 0);

    // R13: echo
    setup(8, 0, 0, 0, 1, 0, 0, 3);
    rxd = 1'b0; @(negedge clk);
    check(!txd, "R13 echo txd follows", int'(txd), 0);
    rxd = 1'b1;
    repeat (cur_n) @(negedge clk);
    drive_bits(mk_frame(9'h0E7, 8, 0, 1'b0, 1'b1), 10);
    wait_rx(got);
    check(got && rx_data == 9'h0E7, "R13 echo receiver works", int'(rx_data), 231);
    do_read();

    finish_run();
  end
endmodule